// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor attachment and decides what happens to an instruction that reaches the execute stage. When the instruction is live (not flushed by an earlier branch), lies in coprocessor or undefined instruction space and passes its condition test, the sequencer commits it by pulling an active-low issue strobe low. It then samples a two-line active-low response from the coprocessor and settles on one of three outcomes: the core continues, the core stalls until the coprocessor releases it, or the core takes an undefined-instruction trap.

The controller has five states. IDLE waits for a qualified instruction. ISSUE holds the strobe low for one cycle and samples the response. WAIT holds the strobe low, asserts stall and samples the response each cycle. DONE emits a one-cycle completion pulse. TRAP emits a one-cycle trap request. The transitions are these:
- IDLE→ISSUE on a qualified instruction.
- ISSUE→DONE on response 00.
- ISSUE→WAIT on response 01.
- ISSUE→TRAP on response 11 or 10.
- WAIT→DONE when the second line falls while the first stays low.
- WAIT→TRAP on a code other than 00 or 01, or when the timeout expires.
- DONE→IDLE and TRAP→IDLE unconditionally.

A busy-wait that lasts too long is ended by a cycle counter that forces the trap.

Top module: `cp_handshake_seq`

## Requirements
- R1: After reset the block is in IDLE with `issue_n`=1 and `stall`, `trap`, `done` all 0.
- R2: An instruction is issued (`issue_n` driven 0 in the next cycle) only when `ex_valid`=1, `cp_space`=1, `cond_pass`=1 and `flush`=0 are sampled together in IDLE.
- R3: If any issue condition fails, `issue_n` stays 1 and no `stall`, `trap` or `done` is produced.
- R4: `issue_n` is 0 in every cycle spent in ISSUE or WAIT, and 1 in all other states.
- R5: A response of `resp_a_n`=0, `resp_b_n`=0 sampled in ISSUE produces `done`=1 in the following cycle, with no stall.
- R6: A response of `resp_a_n`=0, `resp_b_n`=1 sampled in ISSUE moves the block to WAIT. `stall`=1 holds for every WAIT cycle.
- R7: In WAIT, a response of 00 ends the wait and produces a single `done` pulse in the next cycle.
- R8: A response of `resp_a_n`=1, `resp_b_n`=1 (absent) sampled in ISSUE or WAIT produces `trap`=1 in the next cycle.
- R9: The invalid response `resp_a_n`=1, `resp_b_n`=0 is handled like absent and raises `trap`.
- R10: After `TIMEOUT` consecutive WAIT cycles without release, the block raises `trap`.
- R11: `done` and `trap` are single-cycle pulses and are never high together. Each is followed by a return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Instruction present in execute stage |
| cp_space | input | 1 | Instruction lies in coprocessor/undefined space |
| cond_pass | input | 1 | Condition test passed |
| flush | input | 1 | Instruction squashed by a preceding branch |
| resp_a_n | input | 1 | Coprocessor response line A, active low |
| resp_b_n | input | 1 | Coprocessor response line B, active low |
| issue_n | output | 1 | Active-low commit strobe to the coprocessor |
| stall | output | 1 | Pipeline stall request |
| trap | output | 1 | Undefined-instruction trap request pulse |
| done | output | 1 | Accepted-instruction completion pulse |

## Verification
The assertions assume that the issue qualifiers are meaningful only while the block is in IDLE. They also assume that the coprocessor drives its response lines to settled values before each rising edge in which the strobe is low. The bench therefore changes all inputs on the falling edge only, and it holds the qualifiers low once an issue has started. Response codes are applied one cycle ahead of the edge that samples them. The busy-wait timeout is exercised with a small `TIMEOUT` parameter, so the checker's counter window remains short.

// File: rtl/cp_handshake_pkg.sv
package cp_handshake_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_TRAP  = 3'd4
    } cp_state_t;

    typedef enum logic [1:0] {
        RSP_GO     = 2'b00,
        RSP_BUSY   = 2'b01,
        RSP_BAD    = 2'b10,
        RSP_ABSENT = 2'b11
    } cp_resp_t;
endpackage

// File: rtl/cp_issue_qual.sv
module cp_issue_qual (
    input  logic ex_valid,
    input  logic cp_space,
    input  logic cond_pass,
    input  logic flush,
    output logic qualified
);
    always_comb begin
        qualified = ex_valid && cp_space && cond_pass && !flush;
    end
endmodule

// File: rtl/cp_resp_decode.sv
module cp_resp_decode
    import cp_handshake_pkg::*;
(
    input  logic resp_a_n,
    input  logic resp_b_n,
    output logic rsp_go,
    output logic rsp_busy,
    output logic rsp_reject
);
    cp_resp_t code;

    always_comb begin
        code       = cp_resp_t'({resp_a_n, resp_b_n});
        rsp_go     = 1'b0;
        rsp_busy   = 1'b0;
        rsp_reject = 1'b0;
        unique case (code)
            RSP_GO:     rsp_go     = 1'b1;
            RSP_BUSY:   rsp_busy   = 1'b1;
            RSP_BAD:    rsp_reject = 1'b1;
            RSP_ABSENT: rsp_reject = 1'b1;
        endcase
    end
endmodule

// File: rtl/cp_wait_timer.sv
module cp_wait_timer #(
    parameter int TIMEOUT = 256,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // expired when this is the TIMEOUT-th wait cycle
    always_comb begin
        expired = run && (cnt == CW'(TIMEOUT - 1));
    end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
    import cp_handshake_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ex_valid,
    input  logic cp_space,
    input  logic cond_pass,
    input  logic flush,
    input  logic resp_a_n,
    input  logic resp_b_n,
    output logic issue_n,
    output logic stall,
    output logic trap,
    output logic done
);
    cp_state_t state_q, state_d;
    logic qualified;
    logic rsp_go, rsp_busy, rsp_reject;
    logic wait_expired;

    cp_issue_qual u_qual (
        .ex_valid (ex_valid),
        .cp_space (cp_space),
        .cond_pass(cond_pass),
        .flush    (flush),
        .qualified(qualified)
    );

    cp_resp_decode u_dec (
        .resp_a_n  (resp_a_n),
        .resp_b_n  (resp_b_n),
        .rsp_go    (rsp_go),
        .rsp_busy  (rsp_busy),
        .rsp_reject(rsp_reject)
    );

    cp_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_WAIT),
        .expired(wait_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (qualified) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (rsp_go)        state_d = ST_DONE;
                else if (rsp_busy) state_d = ST_WAIT;
                else               state_d = ST_TRAP;
            end
            ST_WAIT: begin
                if (rsp_go)                           state_d = ST_DONE;
                else if (rsp_reject || wait_expired)  state_d = ST_TRAP;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        issue_n = 1'b1;
        stall   = 1'b0;
        trap    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: issue_n = 1'b0;
            ST_WAIT:  begin issue_n = 1'b0; stall = 1'b1; end
            ST_DONE:  done = 1'b1;
            ST_TRAP:  trap = 1'b1;
            default:  ;
        endcase
    end
endmodule

module cp_handshake_chk #(
    parameter int TIMEOUT = 256
) (
    input logic clk,
    input logic rst_n,
    input logic ex_valid,
    input logic cp_space,
    input logic cond_pass,
    input logic flush,
    input logic resp_a_n,
    input logic resp_b_n,
    input logic issue_n,
    input logic stall,
    input logic trap,
    input logic done
);
    logic [31:0] wait_len;
    logic        idle_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_len <= '0;
        else if (stall) wait_len <= wait_len + 1;
        else wait_len <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_seen <= 1'b0;
        else idle_seen <= 1'b1;
    end

    AST_ISSUE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_seen && $fell(issue_n)) |-> $past(ex_valid && cp_space && cond_pass && !flush)); // R2
    AST_STALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !issue_n); // R4
    AST_GO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_n && !resp_a_n && !resp_b_n) |=> (done && issue_n)); // R5
    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_n && !stall && !resp_a_n && resp_b_n) |=> stall); // R6
    AST_REJECT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_n && resp_a_n) |=> trap); // R9
    AST_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_len <= TIMEOUT); // R10
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({trap, done, stall}) <= 1); // R11
    AST_PULSE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && issue_n)); // R11
    AST_PULSE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (!trap && issue_n)); // R11
endmodule

bind cp_handshake_seq cp_handshake_chk #(.TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/cp_handshake_seq_tb.sv
module cp_handshake_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ex_valid = 0, cp_space = 0, cond_pass = 0, flush = 0;
    logic resp_a_n = 1, resp_b_n = 1;
    logic issue_n, stall, trap, done;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cp_handshake_seq #(.TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .cp_space(cp_space), .cond_pass(cond_pass), .flush(flush),
        .resp_a_n(resp_a_n), .resp_b_n(resp_b_n),
        .issue_n(issue_n), .stall(stall), .trap(trap), .done(done)
    );

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {issue_n,stall,trap,done} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {issue_n, stall, trap, done};
    endfunction

    // inputs change on falling edge; outputs sampled just before that
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic present(logic v, logic c, logic p, logic f);
        ex_valid = v; cp_space = c; cond_pass = p; flush = f;
        step();
        ex_valid = 0; cp_space = 0; cond_pass = 0; flush = 0;
    endtask

    task automatic t_reset();
        check("R1 reset", outs(), 4'b1000);
    endtask

    task automatic t_unqualified();
        present(1, 1, 1, 1); check("R3 flushed", outs(), 4'b1000);
        present(1, 1, 0, 0); check("R3 cond fail", outs(), 4'b1000);
        present(1, 0, 1, 0); check("R3 not cp space", outs(), 4'b1000);
        present(0, 1, 1, 0); check("R3 not valid", outs(), 4'b1000);
        step(); check("R3 still idle", outs(), 4'b1000);
    endtask

    task automatic t_accept();
        resp_a_n = 0; resp_b_n = 0;
        present(1, 1, 1, 0); check("R2 issue strobe", outs(), 4'b0000);
        step(); check("R5 done pulse", outs(), 4'b1001);
        resp_a_n = 1; resp_b_n = 1;
        step(); check("R11 back idle", outs(), 4'b1000);
    endtask

    task automatic t_busy(int n);
        resp_a_n = 0; resp_b_n = 1;
        present(1, 1, 1, 0); check("R4 issue", outs(), 4'b0000);
        for (int i = 0; i < n; i++) begin
            step(); check("R6 stall", outs(), 4'b0100);
        end
        resp_b_n = 0;
        step(); check("R7 done after wait", outs(), 4'b1001);
        resp_a_n = 1; resp_b_n = 1;
        step(); check("R11 done single", outs(), 4'b1000);
    endtask

    task automatic t_absent();
        resp_a_n = 1; resp_b_n = 1;
        present(1, 1, 1, 0); check("R4 issue", outs(), 4'b0000);
        step(); check("R8 trap absent", outs(), 4'b1010);
        step(); check("R11 trap single", outs(), 4'b1000);
    endtask

    task automatic t_invalid();
        resp_a_n = 1; resp_b_n = 0;
        present(1, 1, 1, 0);
        step(); check("R9 trap invalid", outs(), 4'b1010);
        resp_b_n = 1;
        step(); check("R11 idle", outs(), 4'b1000);
    endtask

    task automatic t_wait_absent();
        resp_a_n = 0; resp_b_n = 1;
        present(1, 1, 1, 0);
        step(); check("R6 stall", outs(), 4'b0100);
        resp_a_n = 1; resp_b_n = 1;
        step(); check("R8 trap in wait", outs(), 4'b1010);
        step();
    endtask

    task automatic t_timeout();
        resp_a_n = 0; resp_b_n = 1;
        present(1, 1, 1, 0);
        for (int i = 0; i < TO; i++) begin
            step(); check("R10 stall before timeout", outs(), 4'b0100);
        end
        step(); check("R10 timeout trap", outs(), 4'b1010);
        resp_a_n = 1;
        step(); check("R11 idle after timeout", outs(), 4'b1000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_unqualified();
        t_accept();
        t_busy(1);
        t_busy(3);
        t_absent();
        t_invalid();
        t_wait_absent();
        t_timeout();
        t_accept();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule